// File: doc/BRIEF.md
# Low-Power Stop and Wake Controller

This block sequences a microcontroller's system module into and out of a low-power stop state. The processor announces stop with a single-cycle broadcast strobe that carries its current 3-bit interrupt priority mask. On that strobe the controller stores the mask together with three configuration bits. These bits say whether the module clock stays on during stop, whether the external clock output keeps toggling, and whether the frequency synthesizer's VCO is powered down. The controller itself runs from the oscillator-derived clock, which is never stopped. The periodic timer and the reset and interrupt pin logic therefore stay alive.

The controller has three states. RUN is normal operation. STOPPED is the low-power state, in which gated clocks are held low and the buses stay frozen on the broadcast values. RELOCK is a fixed wait that gives the PLL time to regain lock after its VCO is turned back on. The transitions are: RUN to STOPPED on the stop strobe. STOPPED to RUN on a wake event, if the VCO was kept powered. STOPPED to RELOCK on a wake event, if the VCO was powered down. RELOCK to RUN after `RELOCK_CYCLES` cycles. Any state to RUN on reset, asynchronously. A wake event is a trace request, or a pending interrupt whose level is strictly above the stored mask. Level 7 always wakes the block and is treated as non-maskable. The outputs are clock enables, which the clock tree uses to hold each gated clock low. There is also an indication of the most recent wake cause.

Top module: `lpstop_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the state is RUN: `stop_active`=0, `relock_busy`=0, `modclk_en`=`clkout_en`=`vco_en`=1 and `wake_cause`=2'b01 (reset).
- R2: A `stop_req` sampled high in RUN moves the block to STOPPED at that edge (`stop_active`=1 from then on). `stop_mask`, `keep_modclk`, `keep_clkout` and `vco_off` are captured at that edge only; later changes to them have no effect until the next entry.
- R3: While `stop_active`=1, `modclk_en` equals the captured `keep_modclk` and `clkout_en` equals the captured `keep_clkout`. A clock that is not kept is held low (enable 0).
- R4: In STOPPED, `vco_en` is the inverse of the captured `vco_off`. It is 1 in every other state.
- R5: In STOPPED, an `irq_level` strictly greater than the captured mask causes a wake at the next edge. A level less than or equal to the mask leaves the block in STOPPED, and level 0 never wakes.
- R6: `irq_level`=7 wakes the block even when the captured mask is 7.
- R7: `trace_req` high in STOPPED causes a wake regardless of interrupt level. When trace and a qualifying interrupt occur together, the recorded cause is trace.
- R8: `wake_cause` is 2'b01 after reset, 2'b10 after a trace wake and 2'b11 after an interrupt wake. It is updated at the wake edge and held until the next wake or reset.
- R9: If `vco_off` was captured as 1, a wake enters RELOCK for exactly `RELOCK_CYCLES` cycles. During that time `relock_busy`=1, `stop_active`=1 and `vco_en`=1, and the block then returns to RUN. If `vco_off` was captured as 0, a wake returns straight to RUN.
- R10: `stop_req` is ignored outside RUN, and the wake inputs are ignored outside STOPPED.
- R11: Asserting reset in STOPPED or RELOCK returns the outputs to the R1 values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived controller clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Single-cycle stop broadcast strobe from the CPU |
| stop_mask | input | 3 | Interrupt priority mask carried by the broadcast |
| keep_modclk | input | 1 | Keep the module clock running during stop |
| keep_clkout | input | 1 | Keep the external clock output running during stop |
| vco_off | input | 1 | Power down the synthesizer VCO during stop |
| trace_req | input | 1 | Pending trace exception |
| irq_level | input | 3 | Highest pending interrupt level, 0 = none |
| stop_active | output | 1 | Block is not in RUN |
| relock_busy | output | 1 | PLL relock wait in progress |
| modclk_en | output | 1 | Module clock enable (0 holds the clock low) |
| clkout_en | output | 1 | External clock output enable (0 holds it low) |
| vco_en | output | 1 | Synthesizer VCO power enable |
| wake_cause | output | 2 | Cause of the last wake: 01 reset, 10 trace, 11 interrupt |

## Verification
The hardest behaviour to reach is the interaction at the edges of the relock wait. This covers a stop strobe or a wake input that arrives while RELOCK is counting, and the exact cycle on which RUN resumes. The bench brings the block into STOPPED with the VCO powered down, then wakes it with a level-7 interrupt against a mask of 7. It then pulses the stop strobe and trace request during the wait. A behavioural model, compared on every clock, checks that neither pulse shortens or extends the wait. A reset applied mid-cycle inside STOPPED checks that the return to RUN does not wait for a clock edge.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOPPED = 2'd1,
        ST_RELOCK  = 2'd2
    } lp_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_RESET = 2'b01,
        CAUSE_TRACE = 2'b10,
        CAUSE_IRQ   = 2'b11
    } wake_cause_t;

endpackage

// File: rtl/lpstop_wake_arb.sv
module lpstop_wake_arb
    import lpstop_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             trace_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] mask_q,
    output logic             wake,
    output wake_cause_t      cause
);
    localparam logic [LVL_W-1:0] LVL_NMI = {LVL_W{1'b1}};

    logic irq_hit;

    always_comb begin
        irq_hit = (irq_level > mask_q) || (irq_level == LVL_NMI);
        wake    = trace_req || irq_hit;
        if (trace_req) begin
            cause = CAUSE_TRACE;
        end else if (irq_hit) begin
            cause = CAUSE_IRQ;
        end else begin
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/lpstop_relock_timer.sv
module lpstop_relock_timer #(
    parameter int CYCLES = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        done = run && (cnt_q == LAST);
    end

endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
    import lpstop_pkg::*;
#(
    parameter int RELOCK_CYCLES = 512,
    parameter int LVL_W         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic [LVL_W-1:0] stop_mask,
    input  logic             keep_modclk,
    input  logic             keep_clkout,
    input  logic             vco_off,
    input  logic             trace_req,
    input  logic [LVL_W-1:0] irq_level,
    output logic             stop_active,
    output logic             relock_busy,
    output logic             modclk_en,
    output logic             clkout_en,
    output logic             vco_en,
    output logic [1:0]       wake_cause
);
    lp_state_t        state_q, state_d;
    logic [LVL_W-1:0] mask_q;
    logic             keep_mod_q, keep_clk_q, vco_off_q;
    wake_cause_t      cause_q;
    logic             wake;
    wake_cause_t      wake_src;
    logic             relock_done;
    logic             entering;

    lpstop_wake_arb #(.LVL_W(LVL_W)) u_arb (
        .trace_req (trace_req),
        .irq_level (irq_level),
        .mask_q    (mask_q),
        .wake      (wake),
        .cause     (wake_src)
    );

    lpstop_relock_timer #(.CYCLES(RELOCK_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_RELOCK),
        .done  (relock_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (stop_req) state_d = ST_STOPPED;
            ST_STOPPED: if (wake) state_d = vco_off_q ? ST_RELOCK : ST_RUN;
            ST_RELOCK:  if (relock_done) state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    assign entering = (state_q == ST_RUN) && stop_req;

    // Broadcast capture and wake-cause record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= '0;
            keep_mod_q <= 1'b0;
            keep_clk_q <= 1'b0;
            vco_off_q  <= 1'b0;
            cause_q    <= CAUSE_RESET;
        end else begin
            if (entering) begin
                mask_q     <= stop_mask;
                keep_mod_q <= keep_modclk;
                keep_clk_q <= keep_clkout;
                vco_off_q  <= vco_off;
            end
            if ((state_q == ST_STOPPED) && wake) begin
                cause_q <= wake_src;
            end
        end
    end

    // Output decode
    always_comb begin
        stop_active = 1'b0;
        relock_busy = 1'b0;
        modclk_en   = 1'b1;
        clkout_en   = 1'b1;
        vco_en      = 1'b1;
        unique case (state_q)
            ST_RUN: begin
            end
            ST_STOPPED: begin
                stop_active = 1'b1;
                modclk_en   = keep_mod_q;
                clkout_en   = keep_clk_q;
                vco_en      = !vco_off_q;
            end
            ST_RELOCK: begin
                stop_active = 1'b1;
                relock_busy = 1'b1;
                modclk_en   = keep_mod_q;
                clkout_en   = keep_clk_q;
            end
            default: begin
            end
        endcase
        wake_cause = cause_q;
    end

endmodule

// File: rtl/lpstop_ctrl_chk.sv
module lpstop_ctrl_chk
    import lpstop_pkg::*;
#(
    parameter int RELOCK_CYCLES = 512,
    parameter int LVL_W         = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_req,
    input logic             trace_req,
    input logic [LVL_W-1:0] irq_level,
    input lp_state_t        state_q,
    input logic [LVL_W-1:0] mask_q,
    input logic             keep_mod_q,
    input logic             vco_off_q,
    input logic             stop_active,
    input logic             relock_busy,
    input logic             modclk_en,
    input logic             clkout_en,
    input logic             vco_en
);
    logic [31:0] rl_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rl_cnt <= '0;
        else if (relock_busy) rl_cnt <= rl_cnt + 1;
        else rl_cnt <= '0;
    end

    AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_active |-> (modclk_en && clkout_en && vco_en && !relock_busy)); // R1
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_active && stop_req) |=> (stop_active && !relock_busy)); // R2
    AST_MODCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && !keep_mod_q) |-> !modclk_en); // R3
    AST_VCO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && vco_off_q) |-> !vco_en); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && !trace_req && irq_level <= mask_q
         && irq_level != {LVL_W{1'b1}}) |=> (state_q == ST_STOPPED)); // R5
    AST_LVL7_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && irq_level == {LVL_W{1'b1}}) |=> (state_q != ST_STOPPED)); // R6
    AST_TRACE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && trace_req) |=> (state_q != ST_STOPPED)); // R7
    AST_RELOCK_VCO: assert property (@(posedge clk) disable iff (!rst_n)
        relock_busy |-> (vco_en && stop_active)); // R9
    AST_RELOCK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!relock_busy && rl_cnt != 0) |-> (rl_cnt == 32'(RELOCK_CYCLES))); // R9
    AST_RELOCK_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (relock_busy && stop_req) |=> stop_active); // R10

endmodule

bind lpstop_ctrl lpstop_ctrl_chk #(
    .RELOCK_CYCLES (RELOCK_CYCLES),
    .LVL_W         (LVL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_req    (stop_req),
    .trace_req   (trace_req),
    .irq_level   (irq_level),
    .state_q     (state_q),
    .mask_q      (mask_q),
    .keep_mod_q  (keep_mod_q),
    .vco_off_q   (vco_off_q),
    .stop_active (stop_active),
    .relock_busy (relock_busy),
    .modclk_en   (modclk_en),
    .clkout_en   (clkout_en),
    .vco_en      (vco_en)
);

// File: tb/lpstop_ctrl_bench.sv
`timescale 1ns/1ps
module lpstop_ctrl_bench;
    localparam int RL = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic [2:0] stop_mask = 3'd0;
    logic       keep_modclk = 1'b0;
    logic       keep_clkout = 1'b0;
    logic       vco_off = 1'b0;
    logic       trace_req = 1'b0;
    logic [2:0] irq_level = 3'd0;
    logic       stop_active, relock_busy, modclk_en, clkout_en, vco_en;
    logic [1:0] wake_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lpstop_ctrl #(.RELOCK_CYCLES(RL)) u_lpstop_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_mask(stop_mask),
        .keep_modclk(keep_modclk), .keep_clkout(keep_clkout), .vco_off(vco_off),
        .trace_req(trace_req), .irq_level(irq_level),
        .stop_active(stop_active), .relock_busy(relock_busy),
        .modclk_en(modclk_en), .clkout_en(clkout_en), .vco_en(vco_en),
        .wake_cause(wake_cause)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 = running, 1 = stopped, 2 = waiting for lock
    int m_st, m_mask, m_cnt, m_cause;
    bit m_km, m_kc, m_vo;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_cause <= 1;
            m_mask <= 0; m_km <= 0; m_kc <= 0; m_vo <= 0;
        end else if (m_st == 0) begin
            if (stop_req) begin
                m_st <= 1; m_mask <= int'(stop_mask);
                m_km <= keep_modclk; m_kc <= keep_clkout; m_vo <= vco_off;
            end
        end else if (m_st == 1) begin
            if (trace_req || int'(irq_level) > m_mask || irq_level == 3'd7) begin
                m_cause <= trace_req ? 2 : 3;
                m_st <= m_vo ? 2 : 0;
                m_cnt <= 1;
            end
        end else begin
            if (m_cnt == RL) m_st <= 0;
            else m_cnt <= m_cnt + 1;
        end
    end

    // Full comparison every cycle, away from the edge
    always @(posedge clk) begin
        #1;
        if (!finished) begin
            chk(stop_active == (m_st != 0), "R2 stop_active", stop_active, m_st != 0);
            chk(relock_busy == (m_st == 2), "R9 relock_busy", relock_busy, m_st == 2);
            chk(modclk_en == (m_st == 0 ? 1'b1 : m_km), "R3 modclk_en", modclk_en, m_st == 0 ? 1 : m_km);
            chk(clkout_en == (m_st == 0 ? 1'b1 : m_kc), "R3 clkout_en", clkout_en, m_st == 0 ? 1 : m_kc);
            chk(vco_en == (m_st == 1 ? !m_vo : 1'b1), "R4 vco_en", vco_en, m_st == 1 ? !m_vo : 1);
            chk(int'(wake_cause) == m_cause, "R8 wake_cause", wake_cause, m_cause);
        end
    end

    task automatic enter_stop(input int msk, input bit km, input bit kc, input bit vo);
        @(negedge clk);
        stop_req = 1'b1; stop_mask = 3'(msk);
        keep_modclk = km; keep_clkout = kc; vco_off = vo;
        @(negedge clk);
        stop_req = 1'b0;
        // scramble the broadcast inputs: must have no effect (R2)
        stop_mask = ~stop_mask; keep_modclk = ~km; keep_clkout = ~kc; vco_off = ~vo;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(stop_active == 0 && modclk_en && clkout_en && vco_en, "R1 reset outputs",
            {stop_active, modclk_en, clkout_en, vco_en}, 4'b0111);
        chk(wake_cause == 2'b01, "R1 reset cause", wake_cause, 1);
        rst_n = 1'b1;
        idle(3);

        // R5: masked levels hold, higher level wakes, no relock
        enter_stop(3, 1'b1, 1'b0, 1'b0);
        chk(stop_active == 1 && modclk_en == 1 && clkout_en == 0, "R3 gating in stop",
            {stop_active, modclk_en, clkout_en}, 3'b110);
        irq_level = 3'd2; idle(4);
        irq_level = 3'd3; idle(4);
        chk(stop_active == 1, "R5 level at mask ignored", stop_active, 1);
        irq_level = 3'd4; idle(1);
        irq_level = 3'd0;
        chk(stop_active == 0 && wake_cause == 2'b11, "R5 higher level wakes",
            {stop_active, wake_cause}, 3'b011);
        idle(3);

        // R6: level 7 vs mask 7 with VCO off, then R9 relock
        enter_stop(7, 1'b0, 1'b1, 1'b1);
        chk(vco_en == 0 && modclk_en == 0, "R4 vco off in stop", {vco_en, modclk_en}, 0);
        irq_level = 3'd6; idle(5);
        chk(stop_active == 1, "R5 level below mask 7 ignored", stop_active, 1);
        irq_level = 3'd7; idle(1);
        irq_level = 3'd0;
        chk(relock_busy == 1 && vco_en == 1, "R6 level 7 wakes into relock",
            {relock_busy, vco_en}, 3);
        // R10: stop and trace during relock ignored
        idle(10); stop_req = 1'b1; trace_req = 1'b1; idle(1);
        stop_req = 1'b0; trace_req = 1'b0;
        idle(RL - 12);
        chk(relock_busy == 1, "R9 still relocking before last cycle", relock_busy, 1);
        idle(1);
        chk(stop_active == 0 && relock_busy == 0, "R9 R10 run after exact wait",
            {stop_active, relock_busy}, 0);
        idle(3);

        // R7: trace beats interrupt; level 0 never wakes at mask 0
        enter_stop(0, 1'b0, 1'b0, 1'b0);
        idle(4);
        chk(stop_active == 1, "R5 level 0 ignored", stop_active, 1);
        trace_req = 1'b1; irq_level = 3'd5; idle(1);
        trace_req = 1'b0; irq_level = 3'd0;
        chk(stop_active == 0 && wake_cause == 2'b10, "R7 trace priority",
            {stop_active, wake_cause}, 3'b010);
        idle(3);

        // R11: asynchronous reset from STOPPED
        enter_stop(2, 1'b0, 1'b0, 1'b1);
        idle(2);
        #1 rst_n = 1'b0; #0.5;
        chk(stop_active == 0 && vco_en && modclk_en && clkout_en && wake_cause == 2'b01,
            "R11 async reset", {stop_active, vco_en, modclk_en, clkout_en}, 4'b0111);
        idle(2); rst_n = 1'b1;
        idle(3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule